// File: doc/BRIEF.md
# Timer Compare CSR Access Permission Checker

This block decides whether a software access to one of the timer compare registers may proceed. It sees the current privilege level, the virtualization flag and the CSR address, plus four enable bits: the timer counter-enable bit and the compare-enable bit at the machine level, and the same two bits at the hypervisor level. It is purely combinational. For every decoded compare address it reports one verdict: the access is allowed, it raises an illegal-instruction fault, or it raises a virtual-instruction fault.

The checks form two layers. The machine layer runs first and can only produce illegal-instruction faults. The guest layer runs only when a guest is active and can only produce virtual-instruction faults. When a guest supervisor is allowed to access the supervisor compare address, the block also flags that the access is redirected to the virtual compare register. Decoding the other CSRs and taking the trap belong to the surrounding pipeline.

Top module: `tcmp_access_guard`

## Requirements
- R1: Privilege encoding is 2'b00 user, 2'b01 supervisor, 2'b11 machine, and 2'b10 is reserved. On a compare address at machine privilege, `allowed_o` is 1 for any value of the flags and enables.
- R2: On a compare address at user privilege or the reserved encoding, with either value of `virt_i`, `illegal_o` is 1.
- R3: On a compare address below machine privilege with `m_tm_en_i` = 0, `illegal_o` is 1.
- R4: On a compare address below machine privilege with `m_cmp_en_i` = 0, `illegal_o` is 1.
- R5: At supervisor privilege with `virt_i` = 1, both machine enables 1 and `h_tm_en_i` = 0, `virt_fault_o` is 1.
- R6: At supervisor privilege with `virt_i` = 1, both machine enables 1 and `h_cmp_en_i` = 0, `virt_fault_o` is 1.
- R7: When a machine-layer condition (R2 to R4) and a guest-layer condition (R5, R6) both hold, only `illegal_o` is 1.
- R8: `redirect_o` is 1 exactly when a guest supervisor (`virt_i` = 1, privilege 2'b01) is allowed on a supervisor compare address (0x14D, or 0x15D for the upper half).
- R9: At supervisor privilege with `virt_i` = 0 and both machine enables 1, accesses to the supervisor addresses (0x14D, 0x15D) and the virtual addresses (0x24D, 0x25D) are allowed with `redirect_o` = 0, whatever the hypervisor enables are.
- R10: A guest supervisor that passes every enable and names a virtual compare address (0x24D, 0x25D) directly gets `virt_fault_o` = 1.
- R11: On any address other than the four compare addresses, all four outputs are 0.
- R12: On a compare address, exactly one of `allowed_o`, `illegal_o` and `virt_fault_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_i | input | 2 | Current privilege level (00 user, 01 supervisor, 11 machine) |
| virt_i | input | 1 | Guest (virtualized) execution is active |
| csr_addr_i | input | 12 | Address of the CSR being accessed |
| m_tm_en_i | input | 1 | Machine-level timer counter-enable bit |
| h_tm_en_i | input | 1 | Hypervisor-level timer counter-enable bit |
| m_cmp_en_i | input | 1 | Machine-level compare-enable bit |
| h_cmp_en_i | input | 1 | Hypervisor-level compare-enable bit |
| allowed_o | output | 1 | Access may proceed |
| illegal_o | output | 1 | Access raises an illegal-instruction fault |
| virt_fault_o | output | 1 | Access raises a virtual-instruction fault |
| redirect_o | output | 1 | Allowed guest access goes to the virtual compare register |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The bench changes the inputs just after a rising clock edge and samples all four outputs at the next falling edge, half a period later, when they have long settled. Every combination of privilege, flag and enables is swept against each compare address and one neighbouring address. Seeded random vectors and directed corner cases for each rule follow the sweep.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

   typedef enum logic [1:0] {
      LVL_USER  = 2'b00,
      LVL_SUPV  = 2'b01,
      LVL_RSVD  = 2'b10,
      LVL_MACH  = 2'b11
   } lvl_e;

   localparam int unsigned CSR_AW = 12;

endpackage

// File: rtl/tcmp_addr_decode.sv
module tcmp_addr_decode #(
   parameter int unsigned      ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] SUP_BASE   = 'h14D,
   parameter logic [ADDR_W-1:0] VIRT_BASE  = 'h24D,
   parameter logic [ADDR_W-1:0] HI_STRIDE  = 'h010,
   parameter bit               HIGH_HALVES = 1'b1,
   parameter bit               HAS_HYP     = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              sup_hit_o,
   output logic              virt_hit_o
);

   localparam logic [ADDR_W-1:0] SUP_HI  = SUP_BASE + HI_STRIDE;
   localparam logic [ADDR_W-1:0] VIRT_HI = VIRT_BASE + HI_STRIDE;

   if (HIGH_HALVES) begin : g_sup_pair
      assign sup_hit_o = (addr_i == SUP_BASE) || (addr_i == SUP_HI);
   end else begin : g_sup_single
      assign sup_hit_o = (addr_i == SUP_BASE);
   end

   if (!HAS_HYP) begin : g_no_virt
      assign virt_hit_o = 1'b0;
   end else if (HIGH_HALVES) begin : g_virt_pair
      assign virt_hit_o = (addr_i == VIRT_BASE) || (addr_i == VIRT_HI);
   end else begin : g_virt_single
      assign virt_hit_o = (addr_i == VIRT_BASE);
   end

endmodule

// File: rtl/tcmp_mach_gate.sv
module tcmp_mach_gate
   import tcmp_pkg::*;
(
   input  lvl_e lvl_i,
   input  logic hit_i,
   input  logic m_tm_en_i,
   input  logic m_cmp_en_i,
   output logic grant_o,
   output logic pass_o,
   output logic illegal_o
);

   always_comb begin
      grant_o   = 1'b0;
      pass_o    = 1'b0;
      illegal_o = 1'b0;
      if (hit_i) begin
         if (lvl_i == LVL_MACH) begin
            grant_o = 1'b1;
         end else if (lvl_i != LVL_SUPV) begin
            illegal_o = 1'b1;
         end else if (!m_tm_en_i || !m_cmp_en_i) begin
            illegal_o = 1'b1;
         end else begin
            pass_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/tcmp_guest_gate.sv
module tcmp_guest_gate #(
   parameter bit HAS_HYP = 1'b1
) (
   input  logic pass_i,
   input  logic virt_i,
   input  logic sup_hit_i,
   input  logic virt_hit_i,
   input  logic h_tm_en_i,
   input  logic h_cmp_en_i,
   output logic ok_o,
   output logic vfault_o,
   output logic redirect_o
);

   logic guest;

   if (HAS_HYP) begin : g_hyp
      assign guest = virt_i;
   end else begin : g_flat
      logic unused_in;
      assign unused_in = virt_i ^ h_tm_en_i ^ h_cmp_en_i ^ sup_hit_i ^ virt_hit_i;
      assign guest = 1'b0;
   end

   always_comb begin
      ok_o       = 1'b0;
      vfault_o   = 1'b0;
      redirect_o = 1'b0;
      if (pass_i) begin
         if (!guest) begin
            ok_o = 1'b1;
         end else if (!h_tm_en_i || !h_cmp_en_i || virt_hit_i) begin
            vfault_o = 1'b1;
         end else begin
            ok_o       = 1'b1;
            redirect_o = sup_hit_i;
         end
      end
   end

endmodule

// File: rtl/tcmp_access_guard.sv
module tcmp_access_guard
   import tcmp_pkg::*;
#(
   parameter int unsigned       ADDR_W      = CSR_AW,
   parameter logic [ADDR_W-1:0] SUP_BASE    = 'h14D,
   parameter logic [ADDR_W-1:0] VIRT_BASE   = 'h24D,
   parameter logic [ADDR_W-1:0] HI_STRIDE   = 'h010,
   parameter bit                HIGH_HALVES = 1'b1,
   parameter bit                HAS_HYP     = 1'b1
) (
   input  logic [1:0]        priv_i,
   input  logic              virt_i,
   input  logic [ADDR_W-1:0] csr_addr_i,
   input  logic              m_tm_en_i,
   input  logic              h_tm_en_i,
   input  logic              m_cmp_en_i,
   input  logic              h_cmp_en_i,
   output logic              allowed_o,
   output logic              illegal_o,
   output logic              virt_fault_o,
   output logic              redirect_o
);

   if (ADDR_W < 12) begin : g_bad_width
      $error("tcmp_access_guard: ADDR_W must be at least 12");
   end
   if (SUP_BASE == VIRT_BASE) begin : g_bad_base
      $error("tcmp_access_guard: compare bases must differ");
   end
   if (HIGH_HALVES && (HI_STRIDE == '0)) begin : g_bad_stride
      $error("tcmp_access_guard: upper-half stride must be nonzero");
   end

   lvl_e lvl;
   logic sup_hit, virt_hit, any_hit;
   logic m_grant, m_pass, m_ill;
   logic g_ok, g_vfault, g_redir;

   assign lvl     = lvl_e'(priv_i);
   assign any_hit = sup_hit | virt_hit;

   tcmp_addr_decode #(
      .ADDR_W(ADDR_W), .SUP_BASE(SUP_BASE), .VIRT_BASE(VIRT_BASE),
      .HI_STRIDE(HI_STRIDE), .HIGH_HALVES(HIGH_HALVES), .HAS_HYP(HAS_HYP)
   ) u_decode (
      .addr_i    (csr_addr_i),
      .sup_hit_o (sup_hit),
      .virt_hit_o(virt_hit)
   );

   tcmp_mach_gate u_mach (
      .lvl_i     (lvl),
      .hit_i     (any_hit),
      .m_tm_en_i (m_tm_en_i),
      .m_cmp_en_i(m_cmp_en_i),
      .grant_o   (m_grant),
      .pass_o    (m_pass),
      .illegal_o (m_ill)
   );

   tcmp_guest_gate #(.HAS_HYP(HAS_HYP)) u_guest (
      .pass_i    (m_pass),
      .virt_i    (virt_i),
      .sup_hit_i (sup_hit),
      .virt_hit_i(virt_hit),
      .h_tm_en_i (h_tm_en_i),
      .h_cmp_en_i(h_cmp_en_i),
      .ok_o      (g_ok),
      .vfault_o  (g_vfault),
      .redirect_o(g_redir)
   );

   assign allowed_o    = m_grant | g_ok;
   assign illegal_o    = m_ill;
   assign virt_fault_o = g_vfault;
   assign redirect_o   = g_redir;

endmodule

// File: rtl/tcmp_access_guard_chk.sv
module tcmp_access_guard_chk #(
   parameter int unsigned       ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] SUP_BASE    = 'h14D,
   parameter logic [ADDR_W-1:0] VIRT_BASE   = 'h24D,
   parameter logic [ADDR_W-1:0] HI_STRIDE   = 'h010,
   parameter bit                HIGH_HALVES = 1'b1,
   parameter bit                HAS_HYP     = 1'b1
) (
   input logic [1:0]        priv_i,
   input logic              virt_i,
   input logic [ADDR_W-1:0] csr_addr_i,
   input logic              m_tm_en_i,
   input logic              h_tm_en_i,
   input logic              m_cmp_en_i,
   input logic              h_cmp_en_i,
   input logic              allowed_o,
   input logic              illegal_o,
   input logic              virt_fault_o,
   input logic              redirect_o
);

   logic known, on_sup, on_virt, on_any, guest_s;

   assign on_sup  = (csr_addr_i == SUP_BASE) ||
                    (HIGH_HALVES && (csr_addr_i == SUP_BASE + HI_STRIDE));
   assign on_virt = HAS_HYP && ((csr_addr_i == VIRT_BASE) ||
                    (HIGH_HALVES && (csr_addr_i == VIRT_BASE + HI_STRIDE)));
   assign on_any  = on_sup | on_virt;
   assign guest_s = HAS_HYP && virt_i && (priv_i == 2'b01);
   assign known   = !$isunknown({priv_i, virt_i, csr_addr_i, m_tm_en_i,
                                 h_tm_en_i, m_cmp_en_i, h_cmp_en_i});

   always_comb begin
      if (known) begin
         p_machine_ok_r1: assert (!(on_any && priv_i == 2'b11) || allowed_o);
         p_user_illegal_r2: assert (!(on_any && priv_i[0] == 1'b0) || illegal_o);
         p_mtm_illegal_r3: assert (!(on_any && priv_i != 2'b11 && !m_tm_en_i) || illegal_o);
         p_mcmp_illegal_r4: assert (!(on_any && priv_i != 2'b11 && !m_cmp_en_i) || illegal_o);
         p_htm_vfault_r5: assert (!(on_any && guest_s && m_tm_en_i && m_cmp_en_i && !h_tm_en_i)
                                  || virt_fault_o);
         p_hcmp_vfault_r6: assert (!(on_any && guest_s && m_tm_en_i && m_cmp_en_i && !h_cmp_en_i)
                                   || virt_fault_o);
         p_redirect_r8: assert (!redirect_o || (allowed_o && guest_s && on_sup));
         p_miss_quiet_r11: assert (on_any ||
                                   {allowed_o, illegal_o, virt_fault_o, redirect_o} == 4'b0000);
         p_one_verdict_r12: assert (!on_any ||
                                    $countones({allowed_o, illegal_o, virt_fault_o}) == 1);
      end
   end

endmodule

bind tcmp_access_guard tcmp_access_guard_chk #(
   .ADDR_W(ADDR_W), .SUP_BASE(SUP_BASE), .VIRT_BASE(VIRT_BASE),
   .HI_STRIDE(HI_STRIDE), .HIGH_HALVES(HIGH_HALVES), .HAS_HYP(HAS_HYP)
) u_chk (
   .priv_i      (priv_i),
   .virt_i      (virt_i),
   .csr_addr_i  (csr_addr_i),
   .m_tm_en_i   (m_tm_en_i),
   .h_tm_en_i   (h_tm_en_i),
   .m_cmp_en_i  (m_cmp_en_i),
   .h_cmp_en_i  (h_cmp_en_i),
   .allowed_o   (allowed_o),
   .illegal_o   (illegal_o),
   .virt_fault_o(virt_fault_o),
   .redirect_o  (redirect_o)
);

// File: tb/tcmp_access_guard_tb.sv
module tcmp_access_guard_tb;

   logic        clk = 1'b0;
   logic [1:0]  priv;
   logic        virt;
   logic [11:0] addr;
   logic        mtm, htm, mcmp, hcmp;
   logic        allowed, illegal, vfault, redir;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #2 clk = ~clk;

   tcmp_access_guard u_dut (
      .priv_i(priv), .virt_i(virt), .csr_addr_i(addr),
      .m_tm_en_i(mtm), .h_tm_en_i(htm), .m_cmp_en_i(mcmp), .h_cmp_en_i(hcmp),
      .allowed_o(allowed), .illegal_o(illegal), .virt_fault_o(vfault), .redirect_o(redir)
   );

   function automatic bit is_cmp(input logic [11:0] a);
      return a == 12'h14D || a == 12'h15D || a == 12'h24D || a == 12'h25D;
   endfunction

   // expected {allowed, illegal, vfault, redirect}
   function automatic logic [3:0] model(input logic [1:0] p, input logic v,
                                        input logic [11:0] a, input logic [3:0] g);
      // g = {mtm, htm, mcmp, hcmp}
      logic s_hit;
      s_hit = (a == 12'h14D) || (a == 12'h15D);
      if (!is_cmp(a))             return 4'b0000;   // R11
      if (p == 2'b11)             return 4'b1000;   // R1
      if (p != 2'b01)             return 4'b0100;   // R2
      if (!g[3] || !g[1])         return 4'b0100;   // R3 R4 R7
      if (!v)                     return 4'b1000;   // R9
      if (!g[2] || !g[0])         return 4'b0010;   // R5 R6
      if (!s_hit)                 return 4'b0010;   // R10
      return 4'b1001;                               // R8
   endfunction

   function automatic string tag(input logic [1:0] p, input logic v,
                                 input logic [11:0] a, input logic [3:0] g);
      if (!is_cmp(a))     return "R11";
      if (p == 2'b11)     return "R1";
      if (p != 2'b01)     return "R2";
      if (!g[3])          return "R3";
      if (!g[1])          return "R4";
      if (!v)             return "R9";
      if (!g[2])          return "R5";
      if (!g[0])          return "R6";
      if (a[9])           return "R10";
      return "R8";
   endfunction

   task automatic drive(input logic [1:0] p, input logic v, input logic [11:0] a,
                        input logic [3:0] g);
      @(posedge clk);
      priv = p; virt = v; addr = a;
      {mtm, htm, mcmp, hcmp} = g;
      @(negedge clk);
   endtask

   task automatic check(input string t, input logic [3:0] exp);
      logic [3:0] got;
      got = {allowed, illegal, vfault, redir};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: priv=%b virt=%b addr=%h got %b expected %b",
                  t, priv, virt, addr, got, exp);
      end
   endtask

   task automatic run(input logic [1:0] p, input logic v, input logic [11:0] a,
                      input logic [3:0] g);
      drive(p, v, a, g);
      check(tag(p, v, a, g), model(p, v, a, g));
      if (is_cmp(a)) begin
         checks++;
         if ($countones({allowed, illegal, vfault}) != 1) begin
            errors++;
            $display("FAIL R12: verdict bits got %b expected one hot",
                     {allowed, illegal, vfault});
         end
      end
   endtask

   initial begin
      logic [11:0] alist [5];
      alist[0] = 12'h14D; alist[1] = 12'h15D; alist[2] = 12'h24D;
      alist[3] = 12'h25D; alist[4] = 12'h14E;
      priv = 2'b00; virt = 1'b0; addr = 12'h000;
      {mtm, htm, mcmp, hcmp} = 4'b0000;

      // idle state: non-compare address gives all zero (R11)
      @(negedge clk);
      check("R11", 4'b0000);

      // directed corners
      drive(2'b11, 1'b1, 12'h24D, 4'b0000); check("R1", 4'b1000);
      drive(2'b00, 1'b1, 12'h14D, 4'b1111); check("R2", 4'b0100);
      drive(2'b10, 1'b0, 12'h15D, 4'b1111); check("R2", 4'b0100);
      drive(2'b01, 1'b0, 12'h14D, 4'b0111); check("R3", 4'b0100);
      drive(2'b01, 1'b1, 12'h14D, 4'b1101); check("R4", 4'b0100);
      drive(2'b01, 1'b1, 12'h15D, 4'b1011); check("R5", 4'b0010);
      drive(2'b01, 1'b1, 12'h14D, 4'b1110); check("R6", 4'b0010);
      drive(2'b01, 1'b1, 12'h14D, 4'b0000); check("R7", 4'b0100);
      drive(2'b01, 1'b1, 12'h14D, 4'b1111); check("R8", 4'b1001);
      drive(2'b01, 1'b1, 12'h15D, 4'b1111); check("R8", 4'b1001);
      drive(2'b01, 1'b0, 12'h24D, 4'b1010); check("R9", 4'b1000);
      drive(2'b01, 1'b0, 12'h14D, 4'b1111); check("R9", 4'b1000);
      drive(2'b01, 1'b1, 12'h25D, 4'b1111); check("R10", 4'b0010);
      drive(2'b01, 1'b1, 12'h14C, 4'b1111); check("R11", 4'b0000);

      // exhaustive sweep, includes R12 one-hot check
      for (int p = 0; p < 4; p++)
         for (int v = 0; v < 2; v++)
            for (int g = 0; g < 16; g++)
               for (int k = 0; k < 5; k++)
                  run(2'(p), 1'(v), alist[k], 4'(g));

      // seeded random
      void'($urandom(32'd1729));
      for (int n = 0; n < 2000; n++) begin
         logic [11:0] a;
         a = ($urandom % 3 == 0) ? 12'($urandom) : alist[$urandom % 4];
         run(2'($urandom), 1'($urandom), a, 4'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule